// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block connects an 8-bit host processor to the register space of a telecom framer. The host bus is set up by two straps. One strap chooses between separate address and data buses and a single shared address/data bus. The other strap chooses between two strobe styles. The first style has separate active-low read and write strobes. The second has one data strobe plus a read/not-write level. The port synchronises the host control pins to the internal clock and tracks the address. It commits writes when the strobe ends, and it drives read data through a pad-enable output. The pad logic sits outside the block, so the data bus is split into input, output and output-enable.

The register space holds 2^AW bytes. Three addresses are status registers. Their bits are set by single-cycle event pulses from the framer and are cleared by a host read. Three further addresses are interrupt masks. All other addresses are plain read/write storage. The interrupt pin is open drain. It is modelled as a pull-low enable: the pad drives zero while the enable is high. A test input floats both the data bus and the interrupt line.

Top module: `hbp_port`

## Requirements
- R1: With `strap_mux`=0, the register address is {`ale_a7`, `addr_lo`} and `d_in`/`d_out` carry data only; a written byte reads back from the same address, and addresses differing only in bit 7 are distinct.
- R2: With `strap_mux`=1, the address is taken from `d_in` when `ale_a7` rises, and `addr_lo` has no effect.
- R3: With `strap_moto`=0, `strb_a` is an active-low read strobe and `strb_b` is an active-low write strobe.
- R4: With `strap_moto`=1, `strb_b` is read (1) / not-write (0), and `strb_a` is a data strobe. The data strobe is active high when `strap_mux`=0 and active low when `strap_mux`=1.
- R5: While `cs_n` is high, strobes cause no write and `d_oe` stays low.
- R6: `d_oe` is high only while `cs_n` is low, a read strobe is active and `test_hiz` is low. `d_out` then shows the addressed byte.
- R7: A write commits the byte present on `d_in` at the strobe's trailing edge, not the byte present when the strobe began.
- R8: Status bytes sit at addresses 0x00, 0x01 and 0x02. Each one gathers event bits from `ev_in[8k+7:8k]` for k=0..2. Host writes to these addresses are ignored.
- R9: A host read of a status byte clears it when the read strobe ends. An event arriving in the same cycle is kept.
- R10: Mask bytes sit at 0x04, 0x05 and 0x06, one for each status byte, and a mask bit of 1 enables its status bit. `irq_oe` is high exactly while any enabled status bit is set.
- R11: `test_hiz`=1 forces `d_oe` and `irq_oe` low. When it returns to 0, a pending interrupt shows again.
- R12: After reset, every register reads 0x00 and `irq_oe` and `d_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_mux | input | 1 | 0: separate buses, 1: shared address/data bus |
| strap_moto | input | 1 | 0: read/write strobes, 1: data strobe with read/not-write |
| test_hiz | input | 1 | Floats data bus and interrupt when high |
| cs_n | input | 1 | Active-low chip select |
| strb_a | input | 1 | Read strobe or data strobe |
| strb_b | input | 1 | Write strobe or read/not-write |
| ale_a7 | input | 1 | Address bit 7 or address latch strobe |
| addr_lo | input | 7 | Address bits 6..0 (separate-bus mode) |
| d_in | input | 8 | Host bus input from the pad |
| d_out | output | 8 | Read data to the pad |
| d_oe | output | 1 | Pad output enable for the data bus |
| ev_in | input | 24 | Status event pulses, 8 per status byte |
| irq_oe | output | 1 | Interrupt pull-low enable (pad drives 0) |

## Verification
All four strap combinations run back-to-back write and readback cycles. Each pair of writes lands on two addresses that differ in a single bit. In separate-bus mode that bit is bit 7, which tells the pin address apart from a shared-bus latch. In shared-bus mode, `addr_lo` carries a junk value, which shows whether the latch rather than the pins supplies the address. Writes with chip select high and writes to status addresses show whether gating works. A write whose data changes in the middle of the strobe tells trailing-edge capture apart from leading-edge capture. Event pulses with the mask off and then on, followed by a read of the status byte, separate latching, masking and clear-on-read. Toggling the test input over a pending interrupt shows that the float is an override and leaves the stored state untouched.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int DW        = 8;
  localparam int NSTAT     = 3;
  localparam int STAT_BASE = 0;
  localparam int MASK_BASE = 4;

  typedef struct packed {
    logic rd;
    logic wr;
  } strobe_t;

  // Active read/write for the selected bus personality
  function automatic strobe_t decode_strobes(logic muxed, logic moto, logic cs_n,
                                             logic pin_a, logic pin_b);
    strobe_t s;
    logic    ds_on;
    s     = '0;
    ds_on = muxed ? !pin_a : pin_a;
    if (!cs_n) begin
      if (moto) begin
        s.rd = ds_on & pin_b;
        s.wr = ds_on & !pin_b;
      end else begin
        s.rd = !pin_a;
        s.wr = !pin_b;
      end
    end
    return s;
  endfunction

  function automatic logic hit(logic [7:0] a, int base, int k);
    return a == 8'(base + k);
  endfunction
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;
endmodule

// File: rtl/hbp_bus_decode.sv
module hbp_bus_decode
  import hbp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          muxed,
  input  logic          moto,
  input  logic          cs_s,
  input  logic          a_s,
  input  logic          b_s,
  input  logic          ale_s,
  input  logic          a_top,
  input  logic [6:0]    a_lo,
  input  logic [DW-1:0] d_in,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] wdata,
  output logic          wr_pulse,
  output logic          rd_done
);
  strobe_t       st;
  logic          rd_q, wr_q, ale_q;
  logic          ale_rise;
  logic [AW-1:0] alat_q, pin_addr;
  logic [7:0]    pin_full;

  assign st       = decode_strobes(muxed, moto, cs_s, a_s, b_s);
  assign ale_rise = muxed & ale_s & !ale_q;
  assign pin_full = {a_top, a_lo};
  assign pin_addr = pin_full[AW-1:0];
  assign cur_addr = muxed ? alat_q : pin_addr;
  assign wr_pulse = wr_q & !st.wr;
  assign rd_done  = rd_q & !st.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      ale_q    <= 1'b0;
      alat_q   <= '0;
      acc_addr <= '0;
      wdata    <= '0;
    end else begin
      rd_q  <= st.rd;
      wr_q  <= st.wr;
      ale_q <= ale_s;
      if (ale_rise) alat_q <= d_in[AW-1:0];
      if (st.rd || st.wr) acc_addr <= cur_addr;
      if (st.wr) wdata <= d_in;
    end
  end

  AST_LATCH_MUX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (alat_q != $past(alat_q)) |-> $past(muxed)) else $error("latch moved in separate-bus mode"); // R2
endmodule

// File: rtl/hbp_regfile.sv
module hbp_regfile
  import hbp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              rd_done,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     rd_addr,
  input  logic [NSTAT*8-1:0] ev_in,
  input  logic              test_hiz,
  output logic [DW-1:0]     rdata,
  output logic              irq_oe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]            mem [DEPTH];
  logic [NSTAT-1:0][DW-1:0] stat_q, mask_q;
  logic [NSTAT-1:0]         is_stat_w, is_mask_w, clr;
  logic                     irq_any;

  always_comb begin
    for (int k = 0; k < NSTAT; k++) begin
      is_stat_w[k] = hit(8'(acc_addr), STAT_BASE, k);
      is_mask_w[k] = hit(8'(acc_addr), MASK_BASE, k);
      clr[k]       = rd_done & is_stat_w[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && !(|is_stat_w) && !(|is_mask_w)) begin
      mem[acc_addr] <= wdata;
    end
  end

  generate
    for (genvar k = 0; k < NSTAT; k++) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q[k] <= '0;
          mask_q[k] <= '0;
        end else begin
          stat_q[k] <= (clr[k] ? '0 : stat_q[k]) | ev_in[8*k +: 8];
          if (we && is_mask_w[k]) mask_q[k] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata = mem[rd_addr];
    for (int k = 0; k < NSTAT; k++) begin
      if (hit(8'(rd_addr), STAT_BASE, k)) rdata = stat_q[k];
      if (hit(8'(rd_addr), MASK_BASE, k)) rdata = mask_q[k];
    end
  end

  always_comb begin
    irq_any = 1'b0;
    for (int k = 0; k < NSTAT; k++) irq_any |= |(stat_q[k] & mask_q[k]);
  end
  assign irq_oe = irq_any & !test_hiz;

  AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|ev_in) && !rd_done) |=> $stable(stat_q)) else $error("status moved"); // R8 R9
  AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask_q)) else $error("mask moved"); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> ($past(|ev_in) || $past(we) || $past(test_hiz))) else $error("irq without cause"); // R10
endmodule

// File: rtl/hbp_port.sv
module hbp_port
  import hbp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_mux,
  input  logic               strap_moto,
  input  logic               test_hiz,
  input  logic               cs_n,
  input  logic               strb_a,
  input  logic               strb_b,
  input  logic               ale_a7,
  input  logic [6:0]         addr_lo,
  input  logic [DW-1:0]      d_in,
  output logic [DW-1:0]      d_out,
  output logic               d_oe,
  input  logic [NSTAT*8-1:0] ev_in,
  output logic               irq_oe
);
  logic [3:0]    ctl_s;
  logic [AW-1:0] cur_addr, acc_addr;
  logic [DW-1:0] wdata;
  logic          wr_pulse, rd_done;
  strobe_t       live;

  hbp_sync #(.W(4), .RST(4'b1110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({cs_n, strb_a, strb_b, ale_a7}), .dout(ctl_s)
  );

  hbp_bus_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .muxed(strap_mux), .moto(strap_moto),
    .cs_s(ctl_s[3]), .a_s(ctl_s[2]), .b_s(ctl_s[1]), .ale_s(ctl_s[0]),
    .a_top(ale_a7), .a_lo(addr_lo), .d_in(d_in),
    .cur_addr(cur_addr), .acc_addr(acc_addr), .wdata(wdata),
    .wr_pulse(wr_pulse), .rd_done(rd_done)
  );

  hbp_regfile #(.AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_pulse), .rd_done(rd_done),
    .acc_addr(acc_addr), .wdata(wdata), .rd_addr(cur_addr),
    .ev_in(ev_in), .test_hiz(test_hiz), .rdata(d_out), .irq_oe(irq_oe)
  );

  assign live = decode_strobes(strap_mux, strap_moto, cs_n, strb_a, strb_b);
  assign d_oe = live.rd & !test_hiz;

  AST_TEST_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    test_hiz |-> (!d_oe && !irq_oe)) else $error("pins driven in test"); // R11
  AST_WRITE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(!cs_n, 3)) else $error("write without chip select"); // R5
endmodule

// File: tb/hbp_port_bench.sv
module hbp_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_mux = 1'b0, strap_moto = 1'b0, test_hiz = 1'b0;
  logic        cs_n = 1'b1, strb_a = 1'b1, strb_b = 1'b1, ale_a7 = 1'b0;
  logic [6:0]  addr_lo = '0;
  logic [7:0]  d_in = '0;
  logic [7:0]  d_out;
  logic        d_oe, irq_oe;
  logic [23:0] ev_in = '0;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  hbp_port u_hbp_port (
    .clk(clk), .rst_n(rst_n), .strap_mux(strap_mux), .strap_moto(strap_moto),
    .test_hiz(test_hiz), .cs_n(cs_n), .strb_a(strb_a), .strb_b(strb_b),
    .ale_a7(ale_a7), .addr_lo(addr_lo), .d_in(d_in), .d_out(d_out),
    .d_oe(d_oe), .ev_in(ev_in), .irq_oe(irq_oe)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic ds_idle();
    return strap_moto ? strap_mux : 1'b1;
  endfunction

  task automatic set_mode(input logic mx, input logic mo);
    cs_n = 1'b1; ale_a7 = 1'b0; strb_b = 1'b1;
    strap_mux = mx; strap_moto = mo;
    strb_a = ds_idle();
    idle(4);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    if (strap_mux) begin
      addr_lo = 7'h55; d_in = a; ale_a7 = 1'b1; idle(3);
      ale_a7 = 1'b0; idle(3);
    end else begin
      ale_a7 = a[7]; addr_lo = a[6:0]; idle(1);
    end
  endtask

  task automatic strobe_on(input logic rd);
    if (strap_moto) begin
      strb_b = rd; strb_a = !ds_idle();
    end else if (rd) strb_a = 1'b0;
    else strb_b = 1'b0;
  endtask

  task automatic strobe_off();
    strb_a = ds_idle();
    if (!strap_moto) strb_b = 1'b1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic sel);
    addr_phase(a);
    d_in = d; cs_n = !sel; strobe_on(1'b0); idle(4);
    strobe_off(); idle(4);
    cs_n = 1'b1; strb_b = 1'b1; idle(3);
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr_phase(a);
    chk(d_oe == 1'b0, "R6 idle float", d_oe, 0);
    cs_n = 1'b0; strobe_on(1'b1); idle(3);
    chk(d_oe == 1'b1, {req, " oe"}, d_oe, 1);
    chk(d_out == exp, req, d_out, exp);
    strobe_off(); idle(4);
    cs_n = 1'b1; idle(2);
    chk(d_oe == 1'b0, "R6 float after read", d_oe, 0);
  endtask

  task automatic pulse_ev(input int idx);
    ev_in[idx] = 1'b1; idle(1); ev_in = '0; idle(2);
  endtask

  task automatic t_reset();
    chk(d_oe == 1'b0 && irq_oe == 1'b0, "R12 outputs", {d_oe, irq_oe}, 0);
    bus_rd(8'h20, 8'h00, "R12 storage");
    bus_rd(8'h04, 8'h00, "R12 mask");
  endtask

  task automatic t_mode(input logic mx, input logic mo, input logic [7:0] base, input string req);
    set_mode(mx, mo);
    bus_wr(base, 8'hA0 ^ base, 1'b1);
    bus_wr(base | 8'h80, 8'h5C ^ base, 1'b1);
    bus_rd(base, 8'hA0 ^ base, req);
    bus_rd(base | 8'h80, 8'h5C ^ base, req);
  endtask

  task automatic t_cs_gate();
    set_mode(1'b0, 1'b0);
    bus_wr(8'h40, 8'h77, 1'b0);
    chk(d_oe == 1'b0, "R5 no drive", d_oe, 0);
    bus_rd(8'h40, 8'h00, "R5 write blocked");
  endtask

  task automatic t_trailing();
    set_mode(1'b0, 1'b0);
    addr_phase(8'h30);
    d_in = 8'h11; cs_n = 1'b0; strb_b = 1'b0; idle(4);
    d_in = 8'h22; idle(4);
    strb_b = 1'b1; idle(4); cs_n = 1'b1; idle(3);
    bus_rd(8'h30, 8'h22, "R7 trailing capture");
  endtask

  task automatic t_status_irq();
    bus_wr(8'h01, 8'hFF, 1'b1);
    bus_rd(8'h01, 8'h00, "R8 status write ignored");
    pulse_ev(8 + 3);
    chk(irq_oe == 1'b0, "R10 masked", irq_oe, 0);
    bus_wr(8'h05, 8'h08, 1'b1);
    chk(irq_oe == 1'b1, "R10 unmasked", irq_oe, 1);
    bus_rd(8'h01, 8'h08, "R8 status latched");
    chk(irq_oe == 1'b0, "R9 irq released", irq_oe, 0);
    bus_rd(8'h01, 8'h00, "R9 cleared on read");
    pulse_ev(16 + 6);
    bus_rd(8'h02, 8'h40, "R8 third status");
  endtask

  task automatic t_test_mode();
    pulse_ev(0);
    bus_wr(8'h04, 8'h01, 1'b1);
    chk(irq_oe == 1'b1, "R10 irq on", irq_oe, 1);
    test_hiz = 1'b1; idle(1);
    chk(irq_oe == 1'b0, "R11 irq float", irq_oe, 0);
    addr_phase(8'h20); cs_n = 1'b0; strobe_on(1'b1); idle(3);
    chk(d_oe == 1'b0, "R11 bus float", d_oe, 0);
    strobe_off(); idle(4); cs_n = 1'b1; idle(2);
    test_hiz = 1'b0; idle(1);
    chk(irq_oe == 1'b1, "R11 irq returns", irq_oe, 1);
    bus_rd(8'h00, 8'h01, "R9 clear stat0");
    chk(irq_oe == 1'b0, "R10 irq off", irq_oe, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(3);
    t_reset();
    t_mode(1'b0, 1'b0, 8'h1A, "R1 R3 separate read/write strobes");
    t_mode(1'b1, 1'b0, 8'h2B, "R2 R3 shared bus read/write strobes");
    t_mode(1'b0, 1'b1, 8'h3C, "R1 R4 separate data strobe high");
    t_mode(1'b1, 1'b1, 8'h4D, "R2 R4 shared data strobe low");
    t_cs_gate();
    t_trailing();
    t_status_irq();
    t_test_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule